// File: doc/BRIEF.md
# Lag-correlation frame detector

This block watches a complex baseband stream that delivers several samples per clock and reports when a frame preamble appears. Preambles built from a repeated 128-sample training sequence correlate strongly with a copy of themselves delayed by one repetition. Noise does not. The block keeps two running sums over a sliding window of samples:

- the lag product, a sample times the conjugate of the sample one repetition earlier;
- the signal energy.

It compares the normalized magnitude of the lag product against a programmable threshold without ever dividing.

A candidate frame must stay above the threshold for a programmable number of consecutive beats before the block raises its detection flag. The flag is meant as a trigger for capture and beam-switching logic downstream. It then stays high for a programmable hold time, or until a clear pulse. While it is high, no new detection is started, so one frame produces one trigger.

Top module: `lagcorr_detect`

## Requirements
- R1: After reset, `det_flag` is low and all internal sample history reads as zero.
- R2: Each beat carries LANES samples. Lane k sits at bits [k*2*DW +: 2*DW], with I in the low DW bits and Q in the high DW bits, both two's complement. Lane 0 is the oldest sample of the beat. The correlation C is the sum, over the WIN most recent samples n, of y[n]·conj(y[n−LAG]). The energy E is the sum of |y[n]|² over the same samples. Samples before the first beat count as zero.
- R3: A beat is above threshold when E is nonzero and (Re(C)² + Im(C)²)·2^(2·TW) ≥ thr² · E². `thr` is an unsigned fraction with TW fractional bits; 0.25 is 2^(TW−2).
- R4: A run counter counts consecutive accepted beats that are above threshold. A beat that is below threshold resets it to zero. When the beat that brings the run to `persist` is accepted at edge t, `det_flag` rises at edge t+1. A `persist` of 0 acts as 1.
- R5: Cycles with `s_valid` low change neither the sums nor the run counter.
- R6: When `hold` is nonzero at the firing edge, `det_flag` stays high for exactly `hold` cycles. When `hold` is zero, it stays high until cleared.
- R7: A high `clr` at an edge forces `det_flag` low after that edge, with priority over a new detection.
- R8: While `det_flag` is high, the run counter is held at zero and no new detection fires. After the flag drops, a full new run of `persist` above-threshold beats is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Beat of samples present this cycle |
| s_data | input | LANES*2*DW | Packed I/Q samples, lane 0 oldest |
| thr | input | TW | Threshold fraction, TW fractional bits |
| persist | input | CW | Beats above threshold required to fire |
| hold | input | CW | Flag duration in cycles, 0 = until cleared |
| clr | input | 1 | Clears the flag |
| det_flag | output | 1 | Frame detected |

## Verification
The bench builds the block with LANES=4, DW=8 and the default lag and window of 128. This makes the lag 32 beats deep, so a full two-period preamble fills the window after 64 beats. Hold expiry, refiring, bubbles and clears are all reached within a few hundred cycles, with 8-bit samples whose exact products a 128-bit behavioural model reproduces. Random noise, a noisy repeated pattern, a pattern with gaps in `s_valid`, a persistence longer than the pattern, and hold-until-clear are each compared against that model on every cycle.

// File: rtl/lagcorr_detect.sv
module lagcorr_detect #(
  parameter int LANES = 16,
  parameter int DW    = 12,
  parameter int LAG   = 128,
  parameter int WIN   = 128,
  parameter int TW    = 16,
  parameter int CW    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  input  logic [LANES*2*DW-1:0]   s_data,
  input  logic [TW-1:0]           thr,
  input  logic [CW-1:0]           persist,
  input  logic [CW-1:0]           hold,
  input  logic                    clr,
  output logic                    det_flag
);
  localparam int LB   = LAG / LANES;
  localparam int WB   = WIN / LANES;
  localparam int BW   = LANES * 2 * DW;
  localparam int PW   = 2 * DW + 2;
  localparam int BPW  = PW + $clog2(LANES) + 1;
  localparam int SW   = PW + $clog2(WIN) + 1;
  localparam int CMPW = 2 * SW + 2 * TW + 2;

  logic [BW-1:0]           hist  [LB];
  logic signed [BPW-1:0]   ph_re [WB];
  logic signed [BPW-1:0]   ph_im [WB];
  logic signed [BPW-1:0]   ph_e  [WB];
  logic signed [BPW-1:0]   p_re, p_im, p_e;
  logic signed [SW-1:0]    c_re, c_im, e_sum;
  logic                    upd, above, fire;
  logic [CW-1:0]           run, hold_cnt, need;

  always_comb begin
    logic signed [PW-1:0] a, b, c, d;
    p_re = '0; p_im = '0; p_e = '0;
    for (int k = 0; k < LANES; k++) begin
      a = PW'($signed(s_data[k*2*DW +: DW]));
      b = PW'($signed(s_data[k*2*DW+DW +: DW]));
      c = PW'($signed(hist[LB-1][k*2*DW +: DW]));
      d = PW'($signed(hist[LB-1][k*2*DW+DW +: DW]));
      p_re = p_re + BPW'(a*c + b*d);
      p_im = p_im + BPW'(b*c - a*d);
      p_e  = p_e  + BPW'(a*a + b*b);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LB; i++) hist[i] <= '0;
      for (int i = 0; i < WB; i++) begin
        ph_re[i] <= '0; ph_im[i] <= '0; ph_e[i] <= '0;
      end
      c_re <= '0; c_im <= '0; e_sum <= '0; upd <= 1'b0;
    end else begin
      upd <= s_valid;
      if (s_valid) begin
        hist[0] <= s_data;
        for (int i = 1; i < LB; i++) hist[i] <= hist[i-1];
        ph_re[0] <= p_re; ph_im[0] <= p_im; ph_e[0] <= p_e;
        for (int i = 1; i < WB; i++) begin
          ph_re[i] <= ph_re[i-1]; ph_im[i] <= ph_im[i-1]; ph_e[i] <= ph_e[i-1];
        end
        c_re  <= c_re  + SW'(p_re) - SW'(ph_re[WB-1]);
        c_im  <= c_im  + SW'(p_im) - SW'(ph_im[WB-1]);
        e_sum <= e_sum + SW'(p_e)  - SW'(ph_e[WB-1]);
      end
    end
  end

  logic signed [2*SW-1:0] sq_re, sq_im, sq_e;
  logic [2*TW-1:0]        thr_sq;
  logic [CMPW-1:0]        lhs, rhs;
  assign sq_re  = c_re * c_re;
  assign sq_im  = c_im * c_im;
  assign sq_e   = e_sum * e_sum;
  assign thr_sq = (2*TW)'(thr) * (2*TW)'(thr);
  assign lhs    = (CMPW'(unsigned'(sq_re)) + CMPW'(unsigned'(sq_im))) << (2*TW);
  assign rhs    = CMPW'(thr_sq) * CMPW'(unsigned'(sq_e));
  assign above  = (e_sum != '0) && (lhs >= rhs);

  assign need = (persist == '0) ? CW'(1) : persist;
  assign fire = !det_flag && upd && above && (({1'b0, run} + 1'b1) >= {1'b0, need});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; det_flag <= 1'b0; hold_cnt <= '0;
    end else begin
      if (det_flag || fire)           run <= '0;
      else if (upd && !above)         run <= '0;
      else if (upd && run != '1)      run <= run + 1'b1;

      if (clr) begin
        det_flag <= 1'b0; hold_cnt <= '0;
      end else if (fire) begin
        det_flag <= 1'b1; hold_cnt <= hold;
      end else if (det_flag && hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == CW'(1)) det_flag <= 1'b0;
      end
    end
  end

  p_rise_needs_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(upd && above));
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !det_flag);
  p_bubble_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> ($stable(c_re) && $stable(c_im) && $stable(e_sum)));
  p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_flag) |-> ($past(clr) || $past(hold_cnt) == CW'(1)));
  p_no_run_while_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_flag |=> run == '0);
endmodule

// File: tb/lagcorr_detect_test.sv
module lagcorr_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4, DW = 8, LAG = 128, WIN = 128, TW = 16, CW = 16;

  logic clk = 0, rst_n = 0, s_valid = 0, clr = 0;
  logic [LANES*2*DW-1:0] s_data = '0;
  logic [TW-1:0] thr = 16'd16384;
  logic [CW-1:0] persist = 16'd32, hold = 16'd20;
  logic det_flag;
  int checks = 0, errors = 0;

  lagcorr_detect #(.LANES(LANES), .DW(DW), .LAG(LAG), .WIN(WIN), .TW(TW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .thr(thr),
    .persist(persist), .hold(hold), .clr(clr), .det_flag(det_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int qre[$], qim[$];
  longint m_cr, m_ci, m_e;
  int m_run, m_hold;
  bit m_flag, m_upd;
  int pat_re[128], pat_im[128];

  function automatic bit m_above();
    logic [127:0] l, r;
    l = (128'(m_cr*m_cr) + 128'(m_ci*m_ci)) << (2*TW);
    r = 128'(thr) * 128'(thr) * 128'(m_e) * 128'(m_e);
    return (m_e != 0) && (l >= r);
  endfunction

  task automatic model_reset();
    qre.delete(); qim.delete();
    for (int i = 0; i < LAG+WIN; i++) begin qre.push_back(0); qim.push_back(0); end
    m_cr = 0; m_ci = 0; m_e = 0; m_run = 0; m_hold = 0; m_flag = 0; m_upd = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int need;
      bit ab, f;
      need = (persist == 0) ? 1 : int'(persist);
      ab = m_above();
      f = !m_flag && m_upd && ab && (m_run + 1 >= need);
      if (m_flag || f) m_run = 0;
      else if (m_upd) m_run = ab ? m_run + 1 : 0;
      if (clr) begin m_flag = 0; m_hold = 0; end
      else if (f) begin m_flag = 1; m_hold = int'(hold); end
      else if (m_flag && m_hold != 0) begin
        if (m_hold == 1) m_flag = 0;
        m_hold = m_hold - 1;
      end
      m_upd = s_valid;
      if (s_valid) begin
        int sz;
        for (int k = 0; k < LANES; k++) begin
          qre.push_back(int'($signed(s_data[k*2*DW +: DW])));
          qim.push_back(int'($signed(s_data[k*2*DW+DW +: DW])));
        end
        while (qre.size() > LAG+WIN) begin void'(qre.pop_front()); void'(qim.pop_front()); end
        sz = qre.size();
        m_cr = 0; m_ci = 0; m_e = 0;
        for (int n = sz-WIN; n < sz; n++) begin
          m_cr += qre[n]*qre[n-LAG] + qim[n]*qim[n-LAG];
          m_ci += qim[n]*qre[n-LAG] - qre[n]*qim[n-LAG];
          m_e  += qre[n]*qre[n] + qim[n]*qim[n];
        end
      end
    end
  end

  string tag = "R4";
  int rises = 0;
  bit prev_flag = 0;
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (det_flag !== m_flag) begin
      errors++;
      $display("FAIL %s per-cycle flag: actual %0b expected %0b at %0t", tag, det_flag, m_flag, $time);
    end
    if (det_flag && !prev_flag) rises++;
    prev_flag = det_flag;
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int pidx = 0;
  task automatic beat(bit pattern, int noise);
    @(negedge clk);
    s_valid = 1;
    for (int k = 0; k < LANES; k++) begin
      int re, im;
      re = $urandom_range(2*noise) - noise;
      im = $urandom_range(2*noise) - noise;
      if (pattern) begin re += pat_re[pidx]; im += pat_im[pidx]; pidx = (pidx+1) % 128; end
      s_data[k*2*DW +: DW] = DW'(re);
      s_data[k*2*DW+DW +: DW] = DW'(im);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); s_valid = 0; end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    for (int i = 0; i < 128; i++) begin
      pat_re[i] = $urandom_range(120) - 60;
      pat_im[i] = $urandom_range(120) - 60;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", det_flag, 0, "flag after reset");

    tag = "R3";
    r0 = rises;
    for (int i = 0; i < 150; i++) beat(0, 3);
    idle(3);
    check("R3", rises - r0, 0, "detections on noise alone");

    tag = "R4";
    r0 = rises;
    for (int i = 0; i < 120; i++) beat(1, 3);
    idle(25);
    check("R4", rises - r0, 1, "detections on repeated pattern");
    check("R6", det_flag, 0, "flag dropped after hold");

    tag = "R8";
    r0 = rises;
    for (int i = 0; i < 90; i++) beat(1, 3);
    idle(25);
    check("R8", rises - r0, 2, "refires after full new run");

    tag = "R5";
    for (int i = 0; i < 80; i++) beat(0, 3);
    r0 = rises;
    for (int i = 0; i < 100; i++) begin beat(1, 2); if (i % 3 == 0) idle(2); end
    idle(25);
    check("R5", rises - r0, 1, "detection with valid bubbles");

    tag = "R6";
    hold = 0;
    for (int i = 0; i < 30; i++) beat(1, 2);
    idle(60);
    check("R6", det_flag, 1, "flag held with zero hold");
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    tag = "R7";
    check("R7", det_flag, 0, "flag after clear");

    tag = "R4";
    hold = 10; persist = 1000;
    r0 = rises;
    for (int i = 0; i < 150; i++) beat(1, 2);
    idle(5);
    check("R4", rises - r0, 0, "no detection with long persistence");

    tag = "R2";
    persist = 0; thr = 16'd0;
    for (int i = 0; i < 80; i++) beat(0, 0);
    idle(2);
    r0 = rises;
    beat(0, 3); idle(3);
    check("R2", rises - r0, 1, "zero threshold and persist fire on one energetic beat");
    check("R3", det_flag, 1, "flag high after nonzero energy beat");

    idle(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule